// File: doc/BRIEF.md
# VLIW Issue-Group Bundle Former

This block takes a stream of 32-bit instructions and packs them into parallel issue groups of up to four operations. The two lowest bits of each instruction, which ordinary 32-bit code always sets to `11`, are given a second meaning. Bit 0 set closes the current group. Bit 1 clear asks for the operation to execute under a predicate. The upper 30 bits are the operation body, and they are carried into the bundle unchanged. Code built without this scheme therefore comes out as a series of one-operation, unpredicated bundles.

Instructions enter on a valid/ready port. An instruction moves only in a cycle where `in_valid` and `in_ready` are both high. Each accepted operation fills the next free slot, starting at slot 0. When the group-closing instruction is accepted, the finished bundle appears on the output from the next cycle. It stays there, unchanged, until a cycle with `out_ready` high. While a bundle waits, `in_ready` is low. A producer must keep `in_valid` and `in_insn` steady until its instruction is taken.

Four operations may be held with no closing mark. If a fifth instruction is then offered, the four are emitted as a bundle with the overflow flag raised. The fifth instruction is not taken at that point. It is taken into slot 0 of the next group once the faulty bundle has drained. A flush drops a partly collected group and emits nothing.

Top module: `vliw_bundler`

## Requirements
- R1: After reset `out_valid` and `out_overflow` are 0 and `in_ready` is 1.
- R2: An accepted instruction with bit 0 = 1 closes its group: `out_valid` rises in the next cycle. An accepted instruction with bit 0 = 0 does not produce a bundle.
- R3: For each valid slot, `out_slot_pred` is 1 when bit 1 of that slot's instruction was 0, and is 0 when that bit was 1.
- R4: Bits 31:2 of each accepted instruction appear unchanged as the operation of its slot.
- R5: Slots fill in arrival order, starting with slot 0. Only the filled slots show `out_slot_valid` = 1, and unused slots show 0.
- R6: An instruction whose low bits are `11` forms a bundle by itself: valid mask `0001`, predicate mask `0000`.
- R7: While `out_valid` is 1, `in_ready` is 0 and every bundle output holds steady until a cycle with `out_ready` = 1. `out_valid` falls in the cycle after that one. With `out_ready` held at 1, a bundle is shown for exactly one cycle.
- R8: With four operations held and no closing mark, the next instruction offered is refused (`in_ready` = 0). In the next cycle the four are emitted with `out_overflow` = 1 and valid mask `1111`. Once that bundle drains, the refused instruction is accepted into slot 0 of a new group.
- R9: A cycle with `flush` = 1 and no bundle waiting clears the partial group, emits nothing and accepts no input, because `flush` takes priority over `in_valid`. A flush while a bundle waits leaves that bundle untouched.
- R10: Slot i's operation sits at `out_ops[30*i +: 30]`. `out_slot_valid[i]` and `out_slot_pred[i]` belong to slot i. Both masks read 0 while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Drop the partly collected group |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken this cycle |
| in_insn | input | 32 | Instruction word; bit 0 = group end, bit 1 = unpredicated |
| out_valid | output | 1 | Bundle present |
| out_ready | input | 1 | Consumer takes the bundle this cycle |
| out_slot_valid | output | 4 | Per-slot valid mask |
| out_slot_pred | output | 4 | Per-slot predicated flag |
| out_ops | output | 120 | Slot operation bodies, 30 bits per slot |
| out_overflow | output | 1 | Bundle was closed because the group held too many operations |

## Verification
The in-RTL assertions check, on every cycle, the stream rules: input is blocked while a bundle waits, a waiting bundle holds steady, slot valids always form a prefix starting at slot 0, an overflow bundle always carries four valid slots, a closing instruction always yields a bundle, and an idle flush never yields one. Only the directed scenarios can show that the right bits reach the right slots: operation bodies, predicate flags from bit 1, arrival order, a refused fifth instruction reappearing in slot 0, and a flushed group leaving no trace in the next bundle.

// File: rtl/vliw_bundle_pkg.sv
package vliw_bundle_pkg;
  localparam int unsigned INSN_W     = 32;
  localparam int unsigned PREFIX_W   = 2;
  localparam int unsigned OP_W       = INSN_W - PREFIX_W;
  localparam int unsigned LAST_BIT   = 0;   // 1 = closes the group
  localparam int unsigned UNPRED_BIT = 1;   // 0 = predicated operation
endpackage

// File: rtl/vliw_prefix_decode.sv
module vliw_prefix_decode
  import vliw_bundle_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output logic              last,
  output logic              pred,
  output logic [OP_W-1:0]   op
);
  always_comb begin
    last = insn[LAST_BIT];
    pred = ~insn[UNPRED_BIT];
    op   = insn[INSN_W-1:PREFIX_W];
  end
endmodule

// File: rtl/vliw_group_ctrl.sv
module vliw_group_ctrl #(
  parameter int unsigned SLOTS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             in_valid,
  input  logic             in_last,
  input  logic             out_ready,
  output logic             in_ready,
  output logic [SLOTS-1:0] wr_en,
  output logic             clr,
  output logic             busy,
  output logic             ovf
);
  localparam int unsigned CNT_W = $clog2(SLOTS + 1);

  logic [CNT_W-1:0] cnt;
  logic full, drain, accept, ovf_fire, flush_hit;

  always_comb begin
    full      = (cnt == CNT_W'(SLOTS));
    drain     = busy && out_ready;
    in_ready  = !busy && !full && !flush;
    accept    = in_valid && in_ready;
    ovf_fire  = in_valid && full && !busy && !flush;
    flush_hit = flush && !busy;
    clr       = drain || flush_hit;
  end

  for (genvar i = 0; i < SLOTS; i++) begin : g_wr
    assign wr_en[i] = accept && (cnt == CNT_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      if (clr)         cnt <= '0;
      else if (accept) cnt <= cnt + CNT_W'(1);

      if (drain) begin
        busy <= 1'b0;
        ovf  <= 1'b0;
      end else if (accept && in_last) begin
        busy <= 1'b1;
      end else if (ovf_fire) begin
        busy <= 1'b1;
        ovf  <= 1'b1;
      end
    end
  end

  p_input_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);
  p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(SLOTS));
  p_flush_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !busy) |=> !busy);
  p_last_emits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> busy);
endmodule

// File: rtl/vliw_slot_bank.sv
module vliw_slot_bank
  import vliw_bundle_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SLOTS-1:0]      wr_en,
  input  logic                  clr,
  input  logic                  pred,
  input  logic [OP_W-1:0]       op,
  output logic [SLOTS-1:0]      slot_v,
  output logic [SLOTS-1:0]      slot_p,
  output logic [SLOTS*OP_W-1:0] slot_ops
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_v[i]               <= 1'b0;
        slot_p[i]               <= 1'b0;
        slot_ops[i*OP_W +: OP_W] <= '0;
      end else if (clr) begin
        slot_v[i] <= 1'b0;
      end else if (wr_en[i]) begin
        slot_v[i]               <= 1'b1;
        slot_p[i]               <= pred;
        slot_ops[i*OP_W +: OP_W] <= op;
      end
    end
  end

  p_one_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
  p_fill_prefix_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_v & (slot_v + SLOTS'(1))) == '0);
endmodule

// File: rtl/vliw_bundler.sv
module vliw_bundler
  import vliw_bundle_pkg::*;
#(
  parameter int unsigned SLOTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [INSN_W-1:0]     in_insn,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [SLOTS-1:0]      out_slot_valid,
  output logic [SLOTS-1:0]      out_slot_pred,
  output logic [SLOTS*OP_W-1:0] out_ops,
  output logic                  out_overflow
);
  logic             dec_last, dec_pred;
  logic [OP_W-1:0]  dec_op;
  logic [SLOTS-1:0] wr_en, slot_v, slot_p;
  logic             clr;

  vliw_prefix_decode u_dec (
    .insn (in_insn),
    .last (dec_last),
    .pred (dec_pred),
    .op   (dec_op)
  );

  vliw_group_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .in_valid  (in_valid),
    .in_last   (dec_last),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .clr       (clr),
    .busy      (out_valid),
    .ovf       (out_overflow)
  );

  vliw_slot_bank #(.SLOTS(SLOTS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .clr      (clr),
    .pred     (dec_pred),
    .op       (dec_op),
    .slot_v   (slot_v),
    .slot_p   (slot_p),
    .slot_ops (out_ops)
  );

  assign out_slot_valid = slot_v & {SLOTS{out_valid}};
  assign out_slot_pred  = slot_p & slot_v & {SLOTS{out_valid}};

  p_bundle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_ops) &&
      $stable(out_slot_valid) && $stable(out_slot_pred) && $stable(out_overflow)));
  p_overflow_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_overflow |-> (out_valid && (&out_slot_valid)));
  p_lead_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_slot_valid[0]);
endmodule

// File: tb/vliw_bundler_test.sv
module vliw_bundler_test;
  localparam int SL = 4;
  localparam int OW = 30;

  logic clk = 0, rst_n = 0, flush = 0, in_valid = 0, out_ready = 0;
  logic [31:0] in_insn = '0;
  logic in_ready, out_valid, out_overflow;
  logic [SL-1:0] out_slot_valid, out_slot_pred;
  logic [SL*OW-1:0] out_ops;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vliw_bundler #(.SLOTS(SL)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_insn(in_insn), .out_valid(out_valid),
    .out_ready(out_ready), .out_slot_valid(out_slot_valid),
    .out_slot_pred(out_slot_pred), .out_ops(out_ops), .out_overflow(out_overflow)
  );

  function automatic logic [31:0] mk(input logic [29:0] op, input logic [1:0] pfx);
    return {op, pfx};
  endfunction

  function automatic logic [29:0] slot_op(input int i);
    return out_ops[i*OW +: OW];
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    in_valid = 1; in_insn = w; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic drain();
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    check("R7 drained", out_valid, 0);
    check("R7 ready after drain", in_ready, 1);
  endtask

  task automatic t_reset();
    check("R1 out_valid", out_valid, 0);
    check("R1 overflow", out_overflow, 0);
    check("R1 in_ready", in_ready, 1);
    check("R10 mask idle", out_slot_valid, 0);
  endtask

  task automatic t_plain();
    push(mk(30'h2BAD_CAFE, 2'b11));
    check("R2 emit", out_valid, 1);
    check("R6 valid mask", out_slot_valid, 4'b0001);
    check("R6 pred mask", out_slot_pred, 4'b0000);
    check("R4 op0", slot_op(0), 30'h2BAD_CAFE);
    check("R7 ready low", in_ready, 0);
    repeat (3) @(negedge clk);
    check("R7 held", out_valid, 1);
    check("R7 held op", slot_op(0), 30'h2BAD_CAFE);
    drain();
  endtask

  task automatic t_group3();
    push(mk(30'h0000_1111, 2'b10));
    check("R2 no emit", out_valid, 0);
    push(mk(30'h0000_2222, 2'b00));
    push(mk(30'h0000_3333, 2'b01));
    check("R2 emit", out_valid, 1);
    check("R5 mask", out_slot_valid, 4'b0111);
    check("R3 pred", out_slot_pred, 4'b0110);
    check("R10 op0", slot_op(0), 30'h1111);
    check("R10 op1", slot_op(1), 30'h2222);
    check("R4 op2", slot_op(2), 30'h3333);
    drain();
  endtask

  task automatic t_zero_wait();
    out_ready = 1;
    push(mk(30'h0ABC_0001, 2'b11));
    check("R7 one cycle on", out_valid, 1);
    @(negedge clk);
    check("R7 one cycle off", out_valid, 0);
    out_ready = 0;
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 4; i++) push(mk(30'(32'h100 + i), 2'b10));
    check("R8 no emit when full", out_valid, 0);
    in_valid = 1; in_insn = mk(30'h0555_5555, 2'b11); #1;
    check("R8 fifth refused", in_ready, 0);
    @(negedge clk);
    check("R8 emit", out_valid, 1);
    check("R8 flag", out_overflow, 1);
    check("R8 mask", out_slot_valid, 4'b1111);
    check("R8 op3", slot_op(3), 30'h103);
    check("R8 still refused", in_ready, 0);
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
    check("R8 flag clear", out_overflow, 0);
    check("R8 ready again", in_ready, 1);
    @(negedge clk);
    in_valid = 0;
    check("R8 new group", out_slot_valid, 4'b0001);
    check("R8 fifth in slot0", slot_op(0), 30'h0555_5555);
    check("R8 no flag", out_overflow, 0);
    drain();
  endtask

  task automatic t_flush();
    push(mk(30'h0DEAD, 2'b10));
    push(mk(30'h0BEEF, 2'b10));
    flush = 1; in_valid = 1; in_insn = mk(30'h0777, 2'b11); #1;
    check("R9 flush priority", in_ready, 0);
    @(negedge clk);
    flush = 0; in_valid = 0;
    check("R9 nothing emitted", out_valid, 0);
    push(mk(30'h0F00D, 2'b11));
    check("R9 fresh mask", out_slot_valid, 4'b0001);
    check("R9 fresh op", slot_op(0), 30'h0F00D);
    flush = 1;
    @(negedge clk);
    flush = 0;
    check("R9 waiting kept", out_valid, 1);
    check("R9 waiting op", slot_op(0), 30'h0F00D);
    drain();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_group3();
    t_zero_wait();
    t_overflow();
    t_flush();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule